// File: doc/BRIEF.md
# Congestion-Gated Output Arbiter with Multicast Timeout

This block sits on the output side of a switch that queues at both its inputs and its outputs. It decides which input may send to each output in each cycle. Every output has a round-robin arbiter. That arbiter is switched off while the output's buffer signals that it is almost full. While it is off, its priority pointer is frozen, so the next grant after the congestion clears follows the same order that was in force before it. Traffic for a congested output simply waits at its input, because no grant reaches that input.

Each input presents the packet at the head of its queue as a destination mask, together with a flag that asks for strictly synchronous multicast. Grants that an input collects are held as reservations until the packet is issued. A packet is issued once every remaining destination is reserved. A timer counts the cycles since the packet first appeared. When the timer reaches a run-time limit and the packet is not strict, the packet is issued to the outputs it already holds. The other destinations remain queued and are served later. A limit of zero means the packet never times out. The head leaves the input queue only when no destination is left.

Top module: `gl_arb`

## Requirements
- R1: Each output grants at most one input per cycle, and only an input that requests it. The search starts at the input after the last one granted and wraps around. After reset the pointer is NIN-1, so input 0 has first priority. A unicast packet issues in the same cycle as its grant.
- R2: While an output's almost-full flag is 1, that output grants nothing, and traffic for it waits at the inputs.
- R3: While an output's flag is set, or while the output is reserved, its round-robin pointer keeps its value. Granting resumes from that pointer once the output is free again.
- R4: A reservation that an input already holds is not withdrawn when the output's almost-full flag rises afterwards.
- R5: A multicast packet issues to its whole remaining destination set in the cycle in which the last missing destination is granted. Its issue mask then equals that set.
- R6: Take a non-strict packet whose cycle count since first presentation (0 in its first cycle) is at least the nonzero limit. If it holds at least one reservation, it issues to the outputs it holds. The unserved destinations stay pending, and the count keeps running from the first presentation.
- R7: A timeout limit of 0 disables partial issue.
- R8: A packet whose strict flag is 1 is never issued partially, whatever the limit.
- R9: The head pop pulses only when the remaining destination set becomes empty. A head presented with an empty mask is popped at once without any issue. A new packet starts its count at 0.
- R10: Each output is reserved by at most one input at a time. After an issue, the output is released in the next cycle.
- R11: After reset, no grant, issue or pop is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid | input | NIN | A head packet is present at input i |
| head_dest | input | NIN*NOUT | Destination mask of input i's head, bits [i*NOUT +: NOUT], bit o = output o |
| head_strict | input | NIN | Head requires fully synchronous multicast |
| out_afull | input | NOUT | Output buffer almost full |
| tmo_limit | input | TW | Timeout in cycles, 0 = never |
| grant | output | NOUT*NIN | Bit o*NIN+i: output o grants input i this cycle |
| issue | output | NIN | Input i transfers its packet this cycle |
| issue_mask | output | NIN*NOUT | Outputs receiving input i's packet, bits [i*NOUT +: NOUT] |
| head_pop | output | NIN | Input i's head is finished and leaves the queue |

## Verification
Some properties are checked on every cycle. Grants are one-hot and go only to requesters. A congested output grants nothing. The pointer holds while its output is gated or reserved. Reservations persist until issue. Each output has at most one owner. Strict packets and packets with a zero limit issue only in full. Other behaviour can only be shown by the bench scenarios. These cover the exact rotation order after a stall, partial issue at the right timer cycle, and the later completion of the leftover destinations. They also cover immediate popping of empty masks, and the freedom from deadlock that timeouts give when multicast packets contend for the same outputs.

// File: rtl/gl_arb_pkg.sv
package gl_arb_pkg;

    localparam int unsigned GL_MAX_PORTS = 32;

    typedef logic [GL_MAX_PORTS-1:0] gl_vec_t;

    // round-robin pick: first set bit after position 'last', wrapping at n
    function automatic gl_vec_t gl_rr_pick(gl_vec_t req, int unsigned n, int unsigned last);
        gl_vec_t pick;
        bit      found;
        pick  = '0;
        found = 1'b0;
        for (int unsigned k = 1; k <= GL_MAX_PORTS; k++) begin
            int unsigned idx;
            idx = (last + k) % n;
            if (k <= n && !found && req[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
        return pick;
    endfunction

endpackage

// File: rtl/gl_rr_gate.sv
module gl_rr_gate
    import gl_arb_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         afull,
    input  logic         locked,
    output logic [N-1:0] gnt
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] ptr;
    } gate_st_t;

    gate_st_t st_d, st_q;
    gl_vec_t  req_w, pick_w;

    always_comb begin
        st_d  = st_q;
        req_w = '0;
        req_w[N-1:0] = req;
        pick_w = gl_rr_pick(req_w, N, int'(st_q.ptr));
        gnt = (!afull && !locked) ? pick_w[N-1:0] : '0;
        for (int unsigned k = 0; k < N; k++) begin
            if (gnt[k]) st_d.ptr = IW'(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ptr <= IW'(N - 1);
        else        st_q <= st_d;
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
    p_grant_req_r1: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
    p_gate_af_r2: assert property (@(posedge clk) disable iff (!rst_n) afull |-> gnt == '0);
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (afull || locked) |=> $stable(st_q.ptr));

endmodule

// File: rtl/gl_mc_track.sv
module gl_mc_track #(
    parameter int unsigned M  = 4,
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv,
    input  logic [M-1:0]  hdest,
    input  logic          hstrict,
    input  logic [M-1:0]  gnt_in,
    input  logic [TW-1:0] limit,
    output logic [M-1:0]  want,
    output logic [M-1:0]  held,
    output logic          issue,
    output logic [M-1:0]  issue_mask,
    output logic          pop
);
    localparam logic [TW-1:0] TMAX = {TW{1'b1}};

    typedef struct packed {
        logic          busy;
        logic          strict;
        logic [M-1:0]  rem;
        logic [M-1:0]  held;
        logic [TW-1:0] timer;
    } trk_st_t;

    trk_st_t       st_d, st_q;
    logic [M-1:0]  cur_rem, nheld, left;
    logic          cur_strict, all_got, tmo;
    logic [TW-1:0] cur_t;

    always_comb begin
        st_d       = st_q;
        cur_rem    = st_q.busy ? st_q.rem : (hv ? hdest : '0);
        cur_strict = st_q.busy ? st_q.strict : (hv && hstrict);
        cur_t      = st_q.busy ? st_q.timer : '0;
        want       = cur_rem & ~st_q.held;
        nheld      = st_q.held | (gnt_in & want);
        all_got    = (cur_rem != '0) && (nheld == cur_rem);
        tmo        = !cur_strict && (limit != '0) && (cur_t >= limit);
        issue      = (cur_rem != '0) && (all_got || (tmo && nheld != '0));
        issue_mask = issue ? nheld : '0;
        left       = cur_rem & ~issue_mask;
        pop        = (!st_q.busy && hv && hdest == '0) || (issue && left == '0);
        st_d.busy   = (cur_rem != '0) && (left != '0);
        st_d.strict = cur_strict;
        st_d.rem    = left;
        st_d.held   = issue ? '0 : nheld;
        if (st_d.busy) st_d.timer = (cur_t == TMAX) ? cur_t : cur_t + 1'b1;
        else           st_d.timer = '0;
    end

    assign held = st_q.held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_keep_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ((st_q.held & $past(st_q.held)) == $past(st_q.held)));
    p_inside_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> ((issue_mask & ~cur_rem) == '0) && (issue_mask != '0));
    p_zero_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && limit == '0) |-> issue_mask == cur_rem);
    p_strict_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cur_strict) |-> issue_mask == cur_rem);
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> st_q.held == '0);

endmodule

// File: rtl/gl_arb.sv
module gl_arb
    import gl_arb_pkg::*;
#(
    parameter int unsigned NIN  = 4,
    parameter int unsigned NOUT = 4,
    parameter int unsigned TW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIN-1:0]       head_valid,
    input  logic [NIN*NOUT-1:0]  head_dest,
    input  logic [NIN-1:0]       head_strict,
    input  logic [NOUT-1:0]      out_afull,
    input  logic [TW-1:0]        tmo_limit,
    output logic [NOUT*NIN-1:0]  grant,
    output logic [NIN-1:0]       issue,
    output logic [NIN*NOUT-1:0]  issue_mask,
    output logic [NIN-1:0]       head_pop
);
    logic [NIN-1:0][NOUT-1:0] want_m, held_m, gin_m, imask_m;
    logic [NOUT-1:0][NIN-1:0] req_t, gnt_t, own_t;
    logic [NOUT-1:0]          locked;

    always_comb begin
        for (int unsigned o = 0; o < NOUT; o++) begin
            for (int unsigned i = 0; i < NIN; i++) begin
                req_t[o][i] = want_m[i][o];
                own_t[o][i] = held_m[i][o];
                gin_m[i][o] = gnt_t[o][i];
                grant[o*NIN + i] = gnt_t[o][i];
            end
            locked[o] = |own_t[o];
        end
        for (int unsigned i = 0; i < NIN; i++) begin
            issue_mask[i*NOUT +: NOUT] = imask_m[i];
        end
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        gl_rr_gate #(.N(NIN)) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_t[o]),
            .afull  (out_afull[o]),
            .locked (locked[o]),
            .gnt    (gnt_t[o])
        );
        p_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(own_t[o]));
    end

    for (genvar i = 0; i < NIN; i++) begin : g_in
        gl_mc_track #(.M(NOUT), .TW(TW)) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .hv         (head_valid[i]),
            .hdest      (head_dest[i*NOUT +: NOUT]),
            .hstrict    (head_strict[i]),
            .gnt_in     (gin_m[i]),
            .limit      (tmo_limit),
            .want       (want_m[i]),
            .held       (held_m[i]),
            .issue      (issue[i]),
            .issue_mask (imask_m[i]),
            .pop        (head_pop[i])
        );
    end

    initial begin
        p_width_ok: assert (NIN <= GL_MAX_PORTS && NIN > 0 && NOUT > 0);
    end

endmodule

// File: tb/test_gl_arb.sv
module test_gl_arb;
    localparam int NI = 4;
    localparam int NO = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] head_valid = '0;
    logic [NI*NO-1:0] head_dest = '0;
    logic [NI-1:0] head_strict = '0;
    logic [NO-1:0] out_afull = '0;
    logic [7:0]    tmo_limit = '0;
    logic [NO*NI-1:0] grant;
    logic [NI-1:0] issue;
    logic [NI*NO-1:0] issue_mask;
    logic [NI-1:0] head_pop;

    gl_arb #(.NIN(NI), .NOUT(NO), .TW(8)) i_gl_arb (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_dest(head_dest),
        .head_strict(head_strict), .out_afull(out_afull), .tmo_limit(tmo_limit),
        .grant(grant), .issue(issue), .issue_mask(issue_mask), .head_pop(head_pop)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // packet store per input: bit4 strict, bits3:0 destinations
    logic [4:0] store [NI][64];
    int hd [NI];
    int tl [NI];

    // reference state
    bit [3:0] mrem [NI];
    bit [3:0] mheld [NI];
    bit       mbusy [NI];
    bit       mstr [NI];
    int       mtmr [NI];
    int       mptr [NO];
    bit [3:0] af;
    int       lim;

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: got %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic push(int i, bit s, bit [3:0] d);
        store[i][tl[i]] = {s, d};
        tl[i]++;
    endtask

    task automatic step(string tag);
        bit [3:0] crem [NI];
        bit [3:0] want [NI];
        bit [3:0] gr [NI];
        bit       cstr [NI];
        bit       hvv [NI];
        int       ct [NI];
        bit [15:0] eg, eim;
        bit [3:0]  eis, epop;
        @(negedge clk);
        cyc++;
        for (int i = 0; i < NI; i++) begin
            hvv[i] = (hd[i] != tl[i]);
            head_valid[i] = hvv[i];
            head_dest[i*NO +: NO] = hvv[i] ? store[i][hd[i]][3:0] : 4'h0;
            head_strict[i] = hvv[i] ? store[i][hd[i]][4] : 1'b0;
        end
        out_afull = af;
        tmo_limit = 8'(lim);
        #1;
        for (int i = 0; i < NI; i++) begin
            crem[i] = mbusy[i] ? mrem[i] : (hvv[i] ? store[i][hd[i]][3:0] : 4'h0);
            cstr[i] = mbusy[i] ? mstr[i] : (hvv[i] && store[i][hd[i]][4]);
            ct[i]   = mbusy[i] ? mtmr[i] : 0;
            want[i] = crem[i] & ~mheld[i];
            gr[i]   = 4'h0;
        end
        eg = '0;
        for (int o = 0; o < NO; o++) begin
            bit lk, fnd;
            int st;
            lk = 0; fnd = 0; st = mptr[o];
            for (int i = 0; i < NI; i++) if (mheld[i][o]) lk = 1;
            if (!af[o] && !lk) begin
                for (int k = 1; k <= NI; k++) begin
                    int idx;
                    idx = (st + k) % NI;
                    if (!fnd && want[idx][o]) begin
                        fnd = 1; gr[idx][o] = 1; mptr[o] = idx; eg[o*NI + idx] = 1;
                    end
                end
            end
        end
        eis = '0; eim = '0; epop = '0;
        for (int i = 0; i < NI; i++) begin
            bit [3:0] nh, im, left;
            bit all, tmo, iss, pp;
            nh   = mheld[i] | gr[i];
            all  = (crem[i] != 0) && (nh == crem[i]);
            tmo  = !cstr[i] && lim != 0 && ct[i] >= lim;
            iss  = (crem[i] != 0) && (all || (tmo && nh != 0));
            im   = iss ? nh : 4'h0;
            left = crem[i] & ~im;
            pp   = (!mbusy[i] && hvv[i] && store[i][hd[i]][3:0] == 0) || (iss && left == 0);
            eis[i] = iss; eim[i*NO +: NO] = im; epop[i] = pp;
            mbusy[i] = (crem[i] != 0) && (left != 0);
            mrem[i]  = left;
            mheld[i] = iss ? 4'h0 : nh;
            mstr[i]  = cstr[i];
            mtmr[i]  = mbusy[i] ? ((ct[i] == 255) ? 255 : ct[i] + 1) : 0;
            if (pp) hd[i]++;
        end
        chk(tag, int'(grant), int'(eg), "grant");
        chk(tag, int'(issue), int'(eis), "issue");
        chk(tag, int'(issue_mask), int'(eim), "issue_mask");
        chk(tag, int'(head_pop), int'(epop), "head_pop");
    endtask

    function automatic bit idle();
        for (int i = 0; i < NI; i++) if (hd[i] != tl[i] || mbusy[i]) return 0;
        return 1;
    endfunction

    task automatic drain(string tag);
        int n;
        n = 0;
        while (!idle() && n < 3000) begin
            step(tag);
            n++;
        end
        if (!idle()) chk(tag, 0, 1, "drain");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cyc);
        summary();
    end

    initial begin
        for (int i = 0; i < NI; i++) begin
            hd[i] = 0; tl[i] = 0; mrem[i] = 0; mheld[i] = 0; mbusy[i] = 0; mstr[i] = 0; mtmr[i] = 0;
        end
        for (int o = 0; o < NO; o++) mptr[o] = NO - 1;
        af = 0; lim = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11", int'(grant), 0, "reset grant");
        chk("R11", int'(issue), 0, "reset issue");
        chk("R11", int'(head_pop), 0, "reset pop");

        // R1: unicast contention on output 0, rotation order
        for (int r = 0; r < 3; r++) for (int i = 0; i < NI; i++) push(i, 0, 4'b0001);
        push(2, 0, 4'b0100);
        drain("R1");

        // R2/R3: output 1 congested, then released
        af = 4'b0010;
        push(3, 0, 4'b0010); push(0, 0, 4'b0010); push(1, 0, 4'b0010);
        repeat (6) step("R2/R3");
        af = 4'b0000;
        drain("R2/R3");

        // R4/R5: hold output 0 then congest it; release output 1
        af = 4'b0010;
        push(0, 0, 4'b0011);
        step("R4/R5");
        af = 4'b0011;
        repeat (4) step("R4/R5");
        af = 4'b0001;
        step("R4/R5");
        af = 4'b0000;
        push(1, 0, 4'b0101); push(2, 0, 4'b1010);
        drain("R4/R5");

        // R6/R9: timeout partial issue, remainder served later
        lim = 3;
        af = 4'b0100;
        push(0, 0, 4'b0111);
        push(1, 0, 4'b1001);
        push(2, 0, 4'b1011);
        repeat (12) step("R6/R9");
        af = 4'b0000;
        drain("R6/R9");

        // R7: zero limit never times out
        lim = 0;
        af = 4'b0100;
        push(0, 0, 4'b0110);
        repeat (20) step("R7");
        af = 4'b0000;
        drain("R7");

        // R8: strict packet waits despite a short limit
        lim = 2;
        af = 4'b1000;
        push(1, 1, 4'b1001);
        repeat (15) step("R8");
        af = 4'b0000;
        drain("R8");

        // R9/R10: empty masks and mixed random traffic
        lim = 4;
        push(3, 0, 4'b0000); push(3, 0, 4'b0001);
        drain("R9");
        void'($urandom(7));
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < NI; i++)
                for (int p = 0; p < 6; p++) push(i, 0, 4'($urandom_range(0, 15)));
            for (int c = 0; c < 60; c++) begin
                af = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
                step("R1/R2/R3/R10");
            end
            af = 0;
            drain("R6/R10");
            for (int i = 0; i < NI; i++) begin hd[i] = 0; tl[i] = 0; end
        end
        summary();
    end

endmodule